// File: doc/BRIEF.md
# Fixed-Point ALU with Carry, Overflow and Condition Flags

This block is the integer execution stage of a 32-bit fixed-point unit. Each accepted operation combines operand A with operand B, and the output is loaded into a result register. Add, add-with-carry-in, AND, OR and XOR use both operands. Complement uses only operand A.

Three per-operation update bits control the side effects. The carry-update bit lets the operation load the unsigned carry-out into the carry flag. The overflow-update bit lets it set or clear the overflow flag and also set the sticky summary-overflow flag. The record bit writes a signed compare of the result against zero into one 4-bit field of the condition register, and the summary flag is folded into that field.

A separate write port loads the three flags directly. That port is the only way to clear summary overflow apart from reset. Every state element updates on the clock edge at which the valid strobe is sampled high.

Top module: `fxalu_top`

## Requirements
- R1: Opcode 0 (add) yields A+B modulo 2^32. Opcode 1 (add with carry) yields A+B+C, where C is the current carry flag (0 or 1).
- R2: Opcode 2 yields A AND B, opcode 3 yields A OR B, opcode 4 yields A XOR B, and opcode 5 yields NOT A.
- R3: With the carry-update bit set, the carry flag (flags bit 0) takes the unsigned carry-out of bit 31 for opcodes 0 and 1, and takes 0 for opcodes 2 to 5. With the bit clear, the carry flag keeps its value.
- R4: With the overflow-update bit set and signed overflow on an add, the overflow flag (flags bit 1) and the summary flag (flags bit 2) are both set. Without signed overflow (this includes every logical opcode), only the overflow flag is cleared. With the update bit clear, the overflow flag keeps its value.
- R5: Once set, the summary flag stays set until a flag write or a reset.
- R6: With the record bit set, condition bits 31:28 (field 0, counted from the MSB) are loaded as follows: 1000 if the result is negative, 0100 if it is positive, 0010 if it is zero. All other condition bits keep their values. With the record bit clear, the condition register keeps its value.
- R7: Condition bit 28 is written with the summary flag value that holds after this operation's own flag update.
- R8: When the flag write strobe is high, the flags load flag_wdata on the next edge (bit 2 summary, bit 1 overflow, bit 0 carry). This takes priority over a flag update from an operation in the same cycle.
- R9: With valid low, or with opcode 6 or 7, the result, flags and condition register do not change.
- R10: Reset clears the result, the flags and the condition register to zero.
- R11: All outputs are registered and show an accepted operation's effect on the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| upd_carry | input | 1 | Carry-update enable |
| upd_ovf | input | 1 | Overflow-update enable |
| rec_cond | input | 1 | Record compare into condition field |
| flag_wr | input | 1 | Direct flag write strobe |
| flag_wdata | input | 3 | Flag write value {summary, overflow, carry} |
| res_q | output | 32 | Registered result |
| flags_q | output | 3 | Flags {summary, overflow, carry} |
| cond_q | output | 32 | Condition register |

## Verification
The assertions assume that an opcode outside 0 to 5 is a legal input that only leaves state alone. They also assume the flag write port may coincide with an operation, and that the operand values carry no restriction. The stimulus therefore sweeps a fixed set of operand corner values, including both signed limits, all ones, zero and one. It crosses those values with every opcode, including the two unused codes, and with all eight combinations of the update bits. The carry flag is reseeded through the write port between operand pairs, and one write is deliberately placed on top of an overflowing operation.

// File: rtl/fxalu_pkg.sv
package fxalu_pkg;
   typedef enum logic [2:0] {
      OPC_ADD  = 3'd0,
      OPC_ADDC = 3'd1,
      OPC_AND  = 3'd2,
      OPC_OR   = 3'd3,
      OPC_XOR  = 3'd4,
      OPC_NOT  = 3'd5
   } alu_op_e;

   localparam int FLG_CA = 0;
   localparam int FLG_OV = 1;
   localparam int FLG_SO = 2;
   localparam int FLG_W  = 3;
   localparam int CC_W   = 4;

   localparam logic [CC_W-1:0] CC_NEG  = 4'b1000;
   localparam logic [CC_W-1:0] CC_POS  = 4'b0100;
   localparam logic [CC_W-1:0] CC_ZERO = 4'b0010;
   localparam logic [CC_W-1:0] CC_SO   = 4'b0001;
endpackage

// File: rtl/fxalu_arith.sv
module fxalu_arith #(
   parameter int DW = 32
) (
   input  logic [2:0]    op_code,
   input  logic [DW-1:0] opnd_a,
   input  logic [DW-1:0] opnd_b,
   input  logic          carry_in,
   output logic [DW-1:0] result,
   output logic          carry_out,
   output logic          ovf_out,
   output logic          op_known
);
   import fxalu_pkg::*;

   localparam int XW = DW + 1;

   alu_op_e       op;
   logic          cin;
   logic [XW-1:0] uns_sum;
   logic [XW-1:0] sgn_sum;

   always_comb begin
      op        = alu_op_e'(op_code);
      cin       = (op == OPC_ADDC) ? carry_in : 1'b0;
      uns_sum   = {1'b0, opnd_a} + {1'b0, opnd_b} + {{DW{1'b0}}, cin};
      sgn_sum   = {opnd_a[DW-1], opnd_a} + {opnd_b[DW-1], opnd_b} + {{DW{1'b0}}, cin};
      result    = '0;
      carry_out = 1'b0;
      ovf_out   = 1'b0;
      op_known  = 1'b1;
      case (op_code)
         OPC_ADD, OPC_ADDC: begin
            result    = uns_sum[DW-1:0];
            carry_out = uns_sum[DW];
            ovf_out   = sgn_sum[DW] ^ sgn_sum[DW-1];
         end
         OPC_AND: result = opnd_a & opnd_b;
         OPC_OR:  result = opnd_a | opnd_b;
         OPC_XOR: result = opnd_a ^ opnd_b;
         OPC_NOT: result = ~opnd_a;
         default: op_known = 1'b0;
      endcase
   end
endmodule

// File: rtl/fxalu_flags.sv
module fxalu_flags (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fire,
   input  logic                        ca_en,
   input  logic                        oe_en,
   input  logic                        carry,
   input  logic                        ovf,
   input  logic                        wr,
   input  logic [fxalu_pkg::FLG_W-1:0] wdata,
   output logic [fxalu_pkg::FLG_W-1:0] flags_q,
   output logic                        so_after_op
);
   import fxalu_pkg::*;

   logic [FLG_W-1:0] op_nxt;
   logic [FLG_W-1:0] nxt;

   always_comb begin
      op_nxt = flags_q;
      if (fire) begin
         if (ca_en) op_nxt[FLG_CA] = carry;
         if (oe_en) begin
            if (ovf) begin
               op_nxt[FLG_OV] = 1'b1;
               op_nxt[FLG_SO] = 1'b1;
            end else begin
               op_nxt[FLG_OV] = 1'b0;
            end
         end
      end
      so_after_op = op_nxt[FLG_SO];
      nxt         = wr ? wdata : op_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= nxt;
   end

   AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[FLG_SO] && !wr) |=> flags_q[FLG_SO]); // R5
   AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !(fire && ca_en)) |=> $stable(flags_q[FLG_CA])); // R3
   AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && fire && oe_en && ovf) |=> (flags_q[FLG_OV] && flags_q[FLG_SO])); // R4
   AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (flags_q == $past(wdata))); // R8
endmodule

// File: rtl/fxalu_cond.sv
module fxalu_cond #(
   parameter int DW        = 32,
   parameter int CR_FIELDS = 8,
   parameter int FIELD_SEL = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          fire,
   input  logic                          rec,
   input  logic [DW-1:0]                 result,
   input  logic                          so_in,
   output logic [CR_FIELDS*fxalu_pkg::CC_W-1:0] cond_q
);
   import fxalu_pkg::*;

   localparam int CRW    = CR_FIELDS * CC_W;
   localparam int SEL_HI = CRW - 1 - CC_W * FIELD_SEL;
   localparam int SEL_LO = SEL_HI - CC_W + 1;

   logic [CC_W-1:0] nib;
   logic            upd;

   always_comb begin
      upd = fire && rec;
      if (result[DW-1])  nib = CC_NEG;
      else if (|result)  nib = CC_POS;
      else               nib = CC_ZERO;
      if (so_in) nib = nib | CC_SO;
   end

   for (genvar f = 0; f < CR_FIELDS; f++) begin : g_field
      localparam int HI = CRW - 1 - CC_W * f;
      if (f == FIELD_SEL) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cond_q[HI -: CC_W] <= '0;
            else if (upd) cond_q[HI -: CC_W] <= nib;
         end
      end else begin : g_idle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cond_q[HI -: CC_W] <= '0;
            else        cond_q[HI -: CC_W] <= cond_q[HI -: CC_W];
         end
      end
   end

   AST_CC_ONE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && rec) |=> ($countones(cond_q[SEL_HI -: 3]) == 1)); // R6
   AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(fire && rec) |=> $stable(cond_q)); // R6
   AST_CC_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && rec) |=> (cond_q[SEL_LO] == $past(so_in))); // R7
endmodule

// File: rtl/fxalu_top.sv
module fxalu_top #(
   parameter int DW        = 32,
   parameter int CR_FIELDS = 8,
   parameter int FIELD_SEL = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic [2:0]           op_code,
   input  logic [DW-1:0]        opnd_a,
   input  logic [DW-1:0]        opnd_b,
   input  logic                 upd_carry,
   input  logic                 upd_ovf,
   input  logic                 rec_cond,
   input  logic                 flag_wr,
   input  logic [2:0]           flag_wdata,
   output logic [DW-1:0]        res_q,
   output logic [2:0]           flags_q,
   output logic [CR_FIELDS*4-1:0] cond_q
);
   import fxalu_pkg::*;

   if (DW < 2) begin : g_bad_dw
      $error("fxalu_top: DW must be at least 2");
   end
   if (CR_FIELDS < 1) begin : g_bad_fields
      $error("fxalu_top: CR_FIELDS must be at least 1");
   end
   if (FIELD_SEL < 0 || FIELD_SEL >= CR_FIELDS) begin : g_bad_sel
      $error("fxalu_top: FIELD_SEL out of range");
   end

   logic [DW-1:0] alu_res;
   logic          alu_carry;
   logic          alu_ovf;
   logic          alu_known;
   logic          fire;
   logic          so_after_op;

   fxalu_arith #(.DW(DW)) u_arith (
      .op_code   (op_code),
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .carry_in  (flags_q[FLG_CA]),
      .result    (alu_res),
      .carry_out (alu_carry),
      .ovf_out   (alu_ovf),
      .op_known  (alu_known)
   );

   assign fire = op_valid && alu_known;

   fxalu_flags u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire        (fire),
      .ca_en       (upd_carry),
      .oe_en       (upd_ovf),
      .carry       (alu_carry),
      .ovf         (alu_ovf),
      .wr          (flag_wr),
      .wdata       (flag_wdata),
      .flags_q     (flags_q),
      .so_after_op (so_after_op)
   );

   fxalu_cond #(.DW(DW), .CR_FIELDS(CR_FIELDS), .FIELD_SEL(FIELD_SEL)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire),
      .rec    (rec_cond),
      .result (alu_res),
      .so_in  (so_after_op),
      .cond_q (cond_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    res_q <= '0;
      else if (fire) res_q <= alu_res;
   end

   AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(res_q)); // R9
   AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && upd_carry && !flag_wr && op_code >= 3'd2) |=> !flags_q[FLG_CA]); // R3
endmodule

// File: tb/fxalu_top_test.sv
module fxalu_top_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        upd_carry = 1'b0;
   logic        upd_ovf = 1'b0;
   logic        rec_cond = 1'b0;
   logic        flag_wr = 1'b0;
   logic [2:0]  flag_wdata = '0;
   logic [31:0] res_q;
   logic [2:0]  flags_q;
   logic [31:0] cond_q;

   int total = 0;
   int fails = 0;

   logic [31:0] m_res = '0;
   logic        m_ca = 1'b0, m_ov = 1'b0, m_so = 1'b0;
   logic [31:0] m_cr = '0;

   fxalu_top uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .upd_carry(upd_carry), .upd_ovf(upd_ovf),
      .rec_cond(rec_cond), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
      .res_q(res_q), .flags_q(flags_q), .cond_q(cond_q)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pick(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'h7FFF_FFFF;
         3: return 32'h8000_0000;
         4: return 32'hFFFF_FFFF;
         5: return 32'hFFFF_FFFE;
         6: return 32'h1234_5678;
         default: return 32'h8000_0001;
      endcase
   endfunction

   task automatic check_all(input string rtag);
      chk({rtag, " result"}, res_q, m_res);
      chk("R3 R4 R5 flags", {29'd0, flags_q}, {29'd0, m_so, m_ov, m_ca});
      chk("R6 R7 cond", cond_q, m_cr);
   endtask

   // drives one operation at a falling edge, checks at the next falling edge
   task automatic run_op(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic ca, input logic oe, input logic rc,
                         input logic wr, input logic [2:0] wd);
      logic [31:0] r;
      logic [32:0] us;
      longint      ss;
      logic        cy, ov, cin;
      logic [3:0]  nib;
      cin = (op == 1) ? m_ca : 1'b0;
      cy = 1'b0; ov = 1'b0; r = '0;
      us = {1'b0, a} + {1'b0, b} + {32'd0, cin};
      ss = longint'($signed(a)) + longint'($signed(b)) + longint'(cin);
      case (op)
         0, 1: begin
            r = us[31:0]; cy = us[32];
            ov = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
         end
         2: r = a & b;
         3: r = a | b;
         4: r = a ^ b;
         5: r = ~a;
         default: r = '0;
      endcase
      if (op <= 5) begin
         m_res = r;
         if (ca) m_ca = cy;
         if (oe) begin
            if (ov) begin m_ov = 1'b1; m_so = 1'b1; end
            else m_ov = 1'b0;
         end
         if (rc) begin
            nib = $signed(r) < 0 ? 4'b1000 : (r == 0 ? 4'b0010 : 4'b0100);
            if (m_so) nib = nib | 4'b0001;
            m_cr[31:28] = nib;
         end
      end
      if (wr) {m_so, m_ov, m_ca} = wd;
      op_valid = 1'b1; op_code = 3'(op); opnd_a = a; opnd_b = b;
      upd_carry = ca; upd_ovf = oe; rec_cond = rc;
      flag_wr = wr; flag_wdata = wd;
      @(negedge clk);
      op_valid = 1'b0; flag_wr = 1'b0;
      if (op > 5) check_all("R9 undefined opcode");
      else if (op < 2) check_all("R1 R11");
      else check_all("R2 R11");
   endtask

   task automatic write_flags(input logic [2:0] wd);
      flag_wr = 1'b1; flag_wdata = wd;
      {m_so, m_ov, m_ca} = wd;
      @(negedge clk);
      flag_wr = 1'b0;
      chk("R8 flag write", {29'd0, flags_q}, {29'd0, wd});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_all("R10 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R10 after release");

      for (int ia = 0; ia < 8; ia++) begin
         for (int ib = 0; ib < 8; ib++) begin
            write_flags({2'b00, 1'(ib & 1)});
            for (int op = 0; op < 8; op++) begin
               for (int fl = 0; fl < 8; fl++) begin
                  run_op(op, pick(ia), pick(ib), fl[0], fl[1], fl[2], 1'b0, 3'b000);
               end
            end
         end
      end

      // R5: summary survives later non-overflowing updates
      write_flags(3'b000);
      run_op(0, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000);
      run_op(0, 32'h1, 32'h1, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000);
      chk("R5 summary sticky", {31'd0, flags_q[2]}, 32'd1);
      chk("R7 summary in field", {31'd0, cond_q[28]}, 32'd1);

      // R8: write overrides a simultaneous overflowing add
      run_op(0, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 3'b000);
      chk("R8 write priority", {29'd0, flags_q}, 32'd0);

      // R9: valid low leaves everything
      op_valid = 1'b0; op_code = 3'd0; opnd_a = 32'h5; opnd_b = 32'h6;
      upd_carry = 1'b1; upd_ovf = 1'b1; rec_cond = 1'b1;
      @(negedge clk);
      check_all("R9 valid low");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule